// File: doc/BRIEF.md
# Mailbox Transmit Request and Acknowledge Status

This block keeps four 32-bit status words for the transmit side of a message controller with 32 mailboxes. Each word has one bit per mailbox, and bit n always belongs to mailbox n. The four words are:

- the pending request word;
- the cancel request word;
- the sent-OK word;
- the abort word.

Software uses one write port with a strobe, an address and 32 data bits. The protocol engine reports which mailbox is on the bus through a valid flag and an index. It ends a transmission with per-mailbox strobes, one vector for success and one for abort.

A cancel on an idle pending mailbox takes effect straight away. A cancel on the mailbox that is on the bus waits until that transmission ends. When software and the engine act on the same bit in the same cycle, the fixed rule is that setting wins. A registered interrupt flag gathers the masked sent-OK bits, and also the masked abort bits when abort interrupts are enabled.

Top module: `tx_req_status`

## Requirements
- R1: After reset, all four status words read 0 and `mbxIntFlag` is 0.
- R2: Writing address 0 sets the pending-request bits that are 1 in `wrData`. Bits written as 0 keep their value. A read of address 0 returns the pending word.
- R3: Writing 1 to a bit at address 1 sets that cancel bit, and the cancel word reads back at address 1. If that mailbox is not on the bus, the cancel bit reads 1 for one cycle. In the next cycle, the cancel bit and the pending bit both clear.
- R4: While a mailbox is on the bus (`busyValid` is 1 and `busyIdx` equals n), its cancel bit and its pending bit stay set until a success strobe or an abort strobe arrives for it.
- R5: A success strobe on `doneVec[n]` sets bit n of the sent-OK word (read at address 2) on the next edge. On the same edge, pending bit n and cancel bit n clear.
- R6: An abort strobe on `abortVec[n]` sets bit n of the abort word (read at address 3). On the same edge, pending bit n and cancel bit n clear.
- R7: Writing 1 to a bit at address 2 or 3 clears that sent-OK or abort bit. Bits written as 0 keep their value.
- R8: If software clears a sent-OK or abort bit in the same cycle that the engine sets it, the bit ends up set.
- R9: If software sets a cancel bit in the same cycle that a success or abort would clear it, the cancel bit ends up set.
- R10: `mbxIntFlag` is registered and updates one cycle after the status bits change. It is the OR over all mailboxes of (sent-OK AND mask). When `aaIntEn` is 1, the OR also covers (abort AND mask). Clearing the contributing bits drops the flag one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Software write strobe |
| wrAddr | input | 2 | Write target: 0 pending, 1 cancel, 2 sent-OK, 3 abort |
| wrData | input | 32 | Write data, one bit per mailbox |
| rdAddr | input | 2 | Read select, same map as the write port |
| rdData | output | 32 | Selected status word (combinational) |
| busyValid | input | 1 | A mailbox is currently on the bus |
| busyIdx | input | 5 | Index of the mailbox on the bus |
| doneVec | input | 32 | Per-mailbox success strobes |
| abortVec | input | 32 | Per-mailbox abort strobes |
| intMask | input | 32 | Per-mailbox interrupt mask |
| aaIntEn | input | 1 | Let masked abort bits raise the flag |
| mbxIntFlag | output | 1 | Registered global mailbox interrupt flag |

## Verification
The bench targets three kinds of case: a cancel on an idle mailbox, a cancel on the mailbox that is on the bus, and each same-cycle collision between software and the engine.

- Cancel on an idle mailbox: a design that waited for the bus here would leave the request pending forever.
- Cancel on the busy mailbox: a design that cancelled at once would drop a frame already being sent.
- Collisions: a design with clear-wins logic would lose an acknowledge or a cancel that happened in the same cycle.

A behavioural model, running alongside with both directed and random stimulus, also checks the one-cycle lag of the interrupt flag and the gating of abort bits by their enable.

// File: rtl/tx_req_pkg.sv
package tx_req_pkg;
  parameter int MBX_N = 32;

  // Per-mailbox strobes passed from control to datapath
  typedef struct packed {
    logic [MBX_N-1:0] trsSet;
    logic [MBX_N-1:0] trrSet;
    logic [MBX_N-1:0] taClr;
    logic [MBX_N-1:0] aaClr;
    logic [MBX_N-1:0] onBus;
    logic [MBX_N-1:0] done;
    logic [MBX_N-1:0] abort;
  } txStrobes_t;

  typedef enum logic [1:0] {
    ADDR_PEND  = 2'd0,
    ADDR_CANCL = 2'd1,
    ADDR_SENT  = 2'd2,
    ADDR_ABORT = 2'd3
  } regSel_e;
endpackage

// File: rtl/tx_req_ctrl.sv
module tx_req_ctrl
  import tx_req_pkg::*;
#(
  parameter int N = MBX_N,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [N-1:0]     wrData,
  input  logic             busyValid,
  input  logic [IDX_W-1:0] busyIdx,
  input  logic [N-1:0]     doneVec,
  input  logic [N-1:0]     abortVec,
  output txStrobes_t       stb
);
  logic [N-1:0] busyOneHot;

  // One-hot decode of the mailbox currently on the bus
  for (genvar i = 0; i < N; i++) begin : g_busy
    assign busyOneHot[i] = busyValid && (busyIdx == IDX_W'(i));
  end

  always_comb begin
    stb.trsSet = (wrEn && wrAddr == ADDR_PEND)  ? wrData : '0;
    stb.trrSet = (wrEn && wrAddr == ADDR_CANCL) ? wrData : '0;
    stb.taClr  = (wrEn && wrAddr == ADDR_SENT)  ? wrData : '0;
    stb.aaClr  = (wrEn && wrAddr == ADDR_ABORT) ? wrData : '0;
    stb.onBus  = busyOneHot;
    stb.done   = doneVec;
    stb.abort  = abortVec;
  end
endmodule

// File: rtl/tx_req_dp.sv
module tx_req_dp
  import tx_req_pkg::*;
#(
  parameter int N = MBX_N
) (
  input  logic         clk,
  input  logic         rstN,
  input  txStrobes_t   stb,
  input  logic [1:0]   rdAddr,
  input  logic [N-1:0] intMask,
  input  logic         aaIntEn,
  output logic [N-1:0] rdData,
  output logic         intFlag
);
  logic [N-1:0] trsQ, trrQ, taQ, aaQ;
  logic [N-1:0] cancel, finish;

  assign cancel = trrQ & ~stb.onBus;     // idle mailbox: cancel at once
  assign finish = stb.done | stb.abort;  // end of transmission

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trsQ    <= '0;
      trrQ    <= '0;
      taQ     <= '0;
      aaQ     <= '0;
      intFlag <= 1'b0;
    end else begin
      trsQ    <= stb.trsSet | (trsQ & ~cancel & ~finish);
      trrQ    <= stb.trrSet | (trrQ & ~cancel & ~finish);   // set wins
      taQ     <= stb.done  | (taQ & ~stb.taClr);            // set wins
      aaQ     <= stb.abort | (aaQ & ~stb.aaClr);            // set wins
      intFlag <= (|(taQ & intMask)) | (aaIntEn & (|(aaQ & intMask)));
    end
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_PEND:  rdData = trsQ;
      ADDR_CANCL: rdData = trrQ;
      ADDR_SENT:  rdData = taQ;
      default:    rdData = aaQ;
    endcase
  end

  assert_cancel_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(trrQ) & ~trrQ) & $past(stb.onBus) & ~$past(finish)) == '0));

  assert_ta_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|stb.done) |=> ((taQ & $past(stb.done)) == $past(stb.done)));

  assert_pend_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|finish) |=> ((trsQ & $past(finish & ~stb.trsSet)) == '0));

  assert_aa_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|stb.abort) |=> ((aaQ & $past(stb.abort)) == $past(stb.abort)));

  assert_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    (|(taQ & intMask)) |=> intFlag);
endmodule

// File: rtl/tx_req_status.sv
module tx_req_status
  import tx_req_pkg::*;
#(
  parameter int N = MBX_N,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [N-1:0]     wrData,
  input  logic [1:0]       rdAddr,
  output logic [N-1:0]     rdData,
  input  logic             busyValid,
  input  logic [IDX_W-1:0] busyIdx,
  input  logic [N-1:0]     doneVec,
  input  logic [N-1:0]     abortVec,
  input  logic [N-1:0]     intMask,
  input  logic             aaIntEn,
  output logic             mbxIntFlag
);
  txStrobes_t stb;

  tx_req_ctrl #(.N(N)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .busyValid(busyValid), .busyIdx(busyIdx),
    .doneVec(doneVec), .abortVec(abortVec), .stb(stb)
  );

  tx_req_dp #(.N(N)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr),
    .intMask(intMask), .aaIntEn(aaIntEn),
    .rdData(rdData), .intFlag(mbxIntFlag)
  );
endmodule

// File: tb/tx_req_status_tb.sv
module tx_req_status_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        busyValid = 1'b0;
  logic [4:0]  busyIdx = '0;
  logic [31:0] doneVec = '0;
  logic [31:0] abortVec = '0;
  logic [31:0] intMask = '0;
  logic        aaIntEn = 1'b0;
  logic        mbxIntFlag;

  int checks = 0;
  int errors = 0;

  bit [31:0] mWord [4];
  bit        mFlag;

  tx_req_status u_dut (.*);

  always #10 clk = ~clk;   // 50 MHz

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: evaluated on each rising edge from pre-edge state
  always @(posedge clk) begin
    bit [31:0] nw [4];
    bit nf;
    if (!rstN) begin
      for (int a = 0; a < 4; a++) mWord[a] = '0;
      mFlag = 1'b0;
    end else begin
      nf = ((mWord[2] & intMask) != 0) || (aaIntEn && ((mWord[3] & intMask) != 0));
      for (int n = 0; n < 32; n++) begin
        bit onBus, ended;
        onBus = busyValid && (busyIdx == n);
        ended = doneVec[n] || abortVec[n];
        for (int a = 0; a < 4; a++) nw[a][n] = mWord[a][n];
        if ((mWord[1][n] && !onBus) || ended) begin
          nw[0][n] = 1'b0;
          nw[1][n] = 1'b0;
        end
        if (wrEn && wrAddr == 2'd0 && wrData[n]) nw[0][n] = 1'b1;
        if (wrEn && wrAddr == 2'd1 && wrData[n]) nw[1][n] = 1'b1;
        if (wrEn && wrAddr == 2'd2 && wrData[n]) nw[2][n] = 1'b0;
        if (wrEn && wrAddr == 2'd3 && wrData[n]) nw[3][n] = 1'b0;
        if (doneVec[n])  nw[2][n] = 1'b1;
        if (abortVec[n]) nw[3][n] = 1'b1;
      end
      for (int a = 0; a < 4; a++) mWord[a] = nw[a];
      mFlag = nf;
    end
    #5;
    if (rstN) begin
      check($sformatf("R%0s_model_addr%0d", (rdAddr == 0) ? "2" : (rdAddr == 1) ? "3" :
            (rdAddr == 2) ? "5" : "6", rdAddr), rdData, mWord[rdAddr]);
      check("R10_model_flag", {31'b0, mbxIntFlag}, {31'b0, mFlag});
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; doneVec = '0; abortVec = '0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
  endtask

  task automatic peek(logic [1:0] a, string req, logic [31:0] exp);
    rdAddr = a;
    #1;
    check(req, rdData, exp);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 4; a++) peek(a[1:0], "R1_reset", 32'h0);
    check("R1_reset_flag", {31'b0, mbxIntFlag}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: set pending bits, zeros keep
    wr(2'd0, 32'h0000_00F1); step();
    peek(2'd0, "R2_set", 32'h0000_00F1);
    wr(2'd0, 32'h0); step();
    peek(2'd0, "R2_zero_write", 32'h0000_00F1);

    // R3: cancel idle mailbox 4
    wr(2'd1, 32'h10); step();
    peek(2'd1, "R3_cancel_visible", 32'h10);
    step();
    peek(2'd1, "R3_cancel_cleared", 32'h0);
    peek(2'd0, "R3_pending_cancelled", 32'h0000_00E1);

    // R4/R5: cancel mailbox 5 while on bus, then success
    busyValid = 1'b1; busyIdx = 5'd5; intMask = 32'h20;
    wr(2'd1, 32'h20); step(); step(); step();
    peek(2'd1, "R4_cancel_held", 32'h20);
    peek(2'd0, "R4_pending_held", 32'h0000_00E1);
    doneVec = 32'h20; step();
    peek(2'd2, "R5_sent_set", 32'h20);
    peek(2'd0, "R5_pending_clear", 32'h0000_00C1);
    peek(2'd1, "R5_cancel_clear", 32'h0);
    check("R10_flag_lag", {31'b0, mbxIntFlag}, 32'h0);
    step();
    check("R10_flag_up", {31'b0, mbxIntFlag}, 32'h1);

    // R6: abort mailbox 6, abort interrupt gating
    busyIdx = 5'd6; intMask = 32'h40;
    abortVec = 32'h40; step();
    peek(2'd3, "R6_abort_set", 32'h40);
    peek(2'd0, "R6_pending_clear", 32'h0000_0081);
    step();
    check("R10_abort_gated", {31'b0, mbxIntFlag}, 32'h0);
    aaIntEn = 1'b1; step(); step();
    check("R10_abort_enabled", {31'b0, mbxIntFlag}, 32'h1);

    // R7: clear by writing 1, zeros keep
    intMask = 32'h20; aaIntEn = 1'b0;
    wr(2'd2, 32'h0); step();
    peek(2'd2, "R7_zero_keep", 32'h20);
    wr(2'd2, 32'h20); step();
    peek(2'd2, "R7_sent_cleared", 32'h0);
    step();
    check("R10_flag_drop", {31'b0, mbxIntFlag}, 32'h0);
    wr(2'd3, 32'h40); step();
    peek(2'd3, "R7_abort_cleared", 32'h0);

    // R8: set wins over clear
    busyIdx = 5'd7;
    wr(2'd2, 32'h80); doneVec = 32'h80; step();
    peek(2'd2, "R8_sent_collision", 32'h80);
    wr(2'd3, 32'h80); abortVec = 32'h80; step();
    peek(2'd3, "R8_abort_collision", 32'h80);

    // R9: cancel set wins over finish clear, mailbox 0 on bus
    busyIdx = 5'd0;
    wr(2'd1, 32'h1); step();
    wr(2'd1, 32'h1); doneVec = 32'h1; step();
    peek(2'd1, "R9_cancel_collision", 32'h1);
    peek(2'd0, "R9_pending_clear", 32'h0);
    busyValid = 1'b0; step(); step();
    peek(2'd1, "R3_late_cancel_clear", 32'h0);

    // Random phase, compared against the model each cycle
    for (int i = 0; i < 400; i++) begin
      wrEn      = ($urandom_range(0, 2) == 0);
      wrAddr    = 2'($urandom_range(0, 3));
      wrData    = $urandom & $urandom;
      busyValid = $urandom_range(0, 1);
      busyIdx   = 5'($urandom_range(0, 31));
      doneVec   = ($urandom_range(0, 3) == 0) ? (32'h1 << busyIdx) : 32'h0;
      abortVec  = ($urandom_range(0, 5) == 0) ? $urandom : 32'h0;
      intMask   = $urandom;
      aaIntEn   = $urandom_range(0, 1);
      rdAddr    = 2'($urandom_range(0, 3));
      @(negedge clk);
    end
    wrEn = 1'b0; doneVec = '0; abortVec = '0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule